// File: doc/BRIEF.md
# DMA Channel Transfer Controller

This block is the control and status engine of one peripheral-to-memory DMA channel. Software programs a control word that sets the number of 32-bit words to move (stored as count minus one), the run mode and the pacing. The block then counts word transfers down to zero and raises an end-of-count flag. Each counted word is signalled to a separate address sequencer through a one-cycle word-advance strobe. The block moves no data and generates no addresses.

In run-once mode the channel stops by itself after the last word. In continuous mode it reloads the programmed count and keeps running. With the double-buffer option the programmed count covers half of the buffer, so each end of count marks one half, and a ping-pong flag toggles to show which half has just finished. A chip-wide enable input, together with a per-channel hold bit, suspends counting. While counting is suspended the remaining count does not change, so software can read a consistent snapshot.

Registers sit on a one-bit-address bus. Address 0 is the control word. Address 1 is the status word. Reads are combinational.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, both registers read 0 and busy, irq, pingPong and wordAdvance are 0.
- R2: With run-once (control bit 27) set, writing control bit 31 = 1 to an idle channel with count field [15:2] = C gives exactly C+1 wordAdvance pulses. After the last pulse the block clears control bit 31, drops busy and sets the end-of-count flag (status bit 30).
- R3: The status field [15:2] reads remaining words minus one (C-K after K advances) while busy, and 0 when idle. While globalEn is low, no advance happens and this field stays stable. Status bit 29 (halted) reads 1 when the channel is busy and either globalEn is low or hold is set. Status bit 31 mirrors busy.
- R4: The end-of-count flag clears only when the status word is written with bit 30 = 1. Writing the status word with bit 30 = 0 leaves the flag unchanged.
- R5: irq is high exactly when the end-of-count flag and control bit 30 (interrupt enable) are both 1.
- R6: With run-once clear, the count reloads from the control field after each end of count and busy stays 1. After K advances the status field reads C-(K mod (C+1)), and the end-of-count flag is set once K > C.
- R7: With double-buffer (control bit 26) set, pingPong (also status bit 28) toggles at every end of count and clears when the channel starts. With double-buffer clear, pingPong stays 0.
- R8: With flow control (control bit 21) set, a word advances only in a cycle where periphReq is high. With flow control clear, a word advances in every enabled cycle.
- R9: While hold (control bit 29) is set, no word advances and the remaining count is frozen.
- R10: Writing the control word with bit 31 = 0 drops busy at that clock edge, and no wordAdvance occurs in that cycle or afterwards.
- R11: A control write with bit 31 = 1 to a busy channel does not reload the counter. Its count field takes effect at the next reload.
- R12: The control word reads back the written bits 31:26, 21:16 and 15:2, and reads 0 in all other bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| globalEn | input | 1 | Chip-wide transfer enable |
| periphReq | input | 1 | Per-word peripheral request strobe |
| wordAdvance | output | 1 | One word counted; advances the address sequencer |
| busy | output | 1 | Channel is running |
| irq | output | 1 | End-of-count interrupt |
| pingPong | output | 1 | Half-buffer indicator in double-buffer mode |

## Verification
Run-once transfers are swept over counts from 1 to 16 words. These runs show that the pulse count equals the programmed count plus one, and that the stop happens on the last word, not one word early or late. Continuous runs in double-buffer mode are swept over advance counts that cross several reloads. The bench compares the remaining count, the ping-pong phase and the end-of-count flag against modulo arithmetic, which separates reload errors from toggle errors. Sparse peripheral request patterns, the hold bit and global-disable windows of known length show that counting tracks only the allowed cycles. A count rewrite in mid-run shows that the new value waits for the reload.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W    = 32;
  localparam int MAX_CNT_W = 14;
  // control word
  localparam int BIT_EN    = 31;
  localparam int BIT_IE    = 30;
  localparam int BIT_HOLD  = 29;
  localparam int BIT_DIR   = 28;
  localparam int BIT_ONCE  = 27;
  localparam int BIT_DBL   = 26;
  localparam int BIT_FLOW  = 21;
  localparam int SEL_LO    = 16;
  localparam int SEL_W     = 5;
  localparam int CNT_LO    = 2;
  // status word
  localparam int ST_BUSY   = 31;
  localparam int ST_EOC    = 30;
  localparam int ST_HALT   = 29;
  localparam int ST_PING   = 28;

  typedef struct packed {
    logic start;
    logic reload;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/dma_chan_count.sv
module dma_chan_count
  import dma_chan_pkg::*;
#(
  parameter int COUNT_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         stb,
  input  logic [COUNT_W-1:0] wrCount,
  input  logic [COUNT_W-1:0] progCount,
  output logic [COUNT_W-1:0] remain,
  output logic               cntZero
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (stb.start) begin
      remain <= wrCount;
    end else if (stb.reload) begin
      remain <= progCount;
    end else if (stb.dec) begin
      remain <= remain - 1'b1;
    end
  end

  assign cntZero = (remain == '0);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int COUNT_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               globalEn,
  input  logic               periphReq,
  input  logic [COUNT_W-1:0] remain,
  input  logic               cntZero,
  output cntStrobe_t         stb,
  output logic [DATA_W-1:0]  ctrlWord,
  output logic               wordAdvance,
  output logic               busy,
  output logic               irq,
  output logic               pingPong
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] CNT_MASK  = ((ONE << COUNT_W) - ONE) << CNT_LO;
  localparam logic [DATA_W-1:0] SEL_MASK  = ((ONE << SEL_W) - ONE) << SEL_LO;
  localparam logic [DATA_W-1:0] FLAG_MASK = (ONE << BIT_EN) | (ONE << BIT_IE) |
    (ONE << BIT_HOLD) | (ONE << BIT_DIR) | (ONE << BIT_ONCE) | (ONE << BIT_DBL) |
    (ONE << BIT_FLOW);
  localparam logic [DATA_W-1:0] CTRL_MASK = FLAG_MASK | SEL_MASK | CNT_MASK;

  logic ctrlWr, staWr, startNow, stopNow, frozen, advance, endOfCount, eocFlag;
  logic [DATA_W-1:0] staWord;

  assign busy       = ctrlWord[BIT_EN];
  assign ctrlWr     = regWr && !regAddr;
  assign staWr      = regWr && regAddr;
  assign startNow   = ctrlWr && regWdata[BIT_EN] && !busy;
  assign stopNow    = ctrlWr && !regWdata[BIT_EN];
  assign frozen     = !globalEn || ctrlWord[BIT_HOLD];
  assign advance    = busy && !stopNow && !frozen &&
                      (!ctrlWord[BIT_FLOW] || periphReq);
  assign endOfCount = advance && cntZero;

  always_comb begin
    stb        = '0;
    stb.start  = startNow;
    stb.reload = endOfCount && !ctrlWord[BIT_ONCE];
    stb.dec    = advance && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (ctrlWr) begin
      ctrlWord <= regWdata & CTRL_MASK;
    end else if (endOfCount && ctrlWord[BIT_ONCE]) begin
      ctrlWord[BIT_EN] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocFlag <= 1'b0;
    end else if (endOfCount) begin
      eocFlag <= 1'b1;
    end else if (staWr && regWdata[ST_EOC]) begin
      eocFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pingPong <= 1'b0;
    end else if (startNow) begin
      pingPong <= 1'b0;
    end else if (endOfCount && ctrlWord[BIT_DBL]) begin
      pingPong <= !pingPong;
    end
  end

  always_comb begin
    staWord          = '0;
    staWord[ST_BUSY] = busy;
    staWord[ST_EOC]  = eocFlag;
    staWord[ST_HALT] = busy && frozen;
    staWord[ST_PING] = pingPong;
    if (busy) begin
      staWord[CNT_LO +: COUNT_W] = remain;
    end
    regRdata = regAddr ? staWord : ctrlWord;
  end

  assign wordAdvance = advance;
  assign irq         = eocFlag && ctrlWord[BIT_IE];
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int COUNT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              globalEn,
  input  logic              periphReq,
  output logic              wordAdvance,
  output logic              busy,
  output logic              irq,
  output logic              pingPong
);
  cntStrobe_t         stb;
  logic [DATA_W-1:0]  ctrlWord;
  logic [COUNT_W-1:0] remain;
  logic               cntZero;

  dma_chan_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .globalEn(globalEn),
    .periphReq(periphReq), .remain(remain), .cntZero(cntZero), .stb(stb),
    .ctrlWord(ctrlWord), .wordAdvance(wordAdvance), .busy(busy), .irq(irq),
    .pingPong(pingPong)
  );

  dma_chan_count #(.COUNT_W(COUNT_W)) u_count (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrCount(regWdata[CNT_LO +: COUNT_W]),
    .progCount(ctrlWord[CNT_LO +: COUNT_W]),
    .remain(remain), .cntZero(cntZero)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
  import dma_chan_pkg::*;
#(
  parameter int COUNT_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic               regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic               globalEn,
  input logic               periphReq,
  input logic               wordAdvance,
  input logic               busy,
  input logic               irq,
  input logic               pingPong,
  input logic [DATA_W-1:0]  ctrlWord,
  input logic [COUNT_W-1:0] remain
);
  logic ctlWrite;
  assign ctlWrite = regWr && !regAddr;

  AST_ADV_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wordAdvance |-> busy); // R2
  AST_ONCE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wordAdvance && ctrlWord[BIT_ONCE] && remain == '0 && !ctlWrite |=> !busy); // R2
  AST_FROZEN_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !wordAdvance); // R3
  AST_REMAIN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wordAdvance && !ctlWrite |=> $stable(remain)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ctrlWord[BIT_IE]); // R5
  AST_PING_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordAdvance && ctrlWord[BIT_DBL] && remain == '0 |=> pingPong != $past(pingPong)); // R7
  AST_FLOW_GATE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[BIT_FLOW] && !periphReq |-> !wordAdvance); // R8
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[BIT_HOLD] |-> !wordAdvance); // R9
  AST_STOP_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrite && !regWdata[BIT_EN] |=> !busy); // R10
endmodule

bind dma_chan_top dma_chan_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .globalEn(globalEn), .periphReq(periphReq),
  .wordAdvance(wordAdvance), .busy(busy), .irq(irq), .pingPong(pingPong),
  .ctrlWord(ctrlWord), .remain(remain)
);

// File: tb/test_dma_chan_top.sv
`timescale 1ns/1ps
module test_dma_chan_top;
  localparam logic [31:0] EN   = 32'h8000_0000;
  localparam logic [31:0] IE   = 32'h4000_0000;
  localparam logic [31:0] HOLD = 32'h2000_0000;
  localparam logic [31:0] ONCE = 32'h0800_0000;
  localparam logic [31:0] DBL  = 32'h0400_0000;
  localparam logic [31:0] FLOW = 32'h0020_0000;
  localparam logic [31:0] EOCB = 32'h4000_0000;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regAddr = 1'b0;
  logic globalEn = 1'b0, periphReq = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic wordAdvance, busy, irq, pingPong;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  dma_chan_top i_dma_chan_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .globalEn(globalEn),
    .periphReq(periphReq), .wordAdvance(wordAdvance), .busy(busy),
    .irq(irq), .pingPong(pingPong)
  );

  function automatic logic [31:0] cnt(input int c);
    return 32'(c) << 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata; regAddr = 1'b0;
  endtask

  task automatic runEn(input int k);
    globalEn = 1'b1;
    repeat (k) @(negedge clk);
    globalEn = 1'b0;
  endtask

  task automatic resetChan();
    globalEn = 1'b0;
    wr(1'b0, 32'h0);
    wr(1'b1, EOCB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, st2;
    int advCnt, pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    rd(1'b0, st); chk("R1 ctrl", st, 0);
    rd(1'b1, st); chk("R1 status", st, 0);
    chk("R1 outputs", {28'b0, wordAdvance, busy, irq, pingPong}, 0);
    @(negedge clk);

    // R12 readback mask
    wr(1'b0, 32'h7FFF_FFFF);
    rd(1'b0, st); chk("R12 readback", st, 32'h7C3F_FFFC);
    resetChan();

    // R2 run-once sweep
    for (int n = 1; n <= 16; n++) begin
      resetChan();
      wr(1'b0, EN | ONCE | cnt(n - 1));
      advCnt = 0;
      globalEn = 1'b1;
      repeat (40) begin
        #1; if (wordAdvance) advCnt++;
        @(negedge clk);
      end
      globalEn = 1'b0;
      chk($sformatf("R2 advances n=%0d", n), 32'(advCnt), 32'(n));
      chk("R2 busy low", {31'b0, busy}, 0);
      rd(1'b1, st); chk("R2 eoc set", st & EOCB, EOCB);
      rd(1'b0, st); chk("R2 enable cleared", st & EN, 0);
    end

    // R4 write-one-to-clear, R5 irq gating (eoc currently set)
    chk("R5 irq off without IE", {31'b0, irq}, 0);
    wr(1'b0, IE);
    #1; chk("R5 irq with IE", {31'b0, irq}, 1);
    wr(1'b1, 32'hBFFF_FFFF);
    rd(1'b1, st); chk("R4 eoc kept on zero write", st & EOCB, EOCB);
    wr(1'b1, EOCB);
    rd(1'b1, st); chk("R4 eoc cleared", st & EOCB, 0);
    chk("R5 irq drops", {31'b0, irq}, 0);

    // R3 snapshot under global disable
    resetChan();
    wr(1'b0, EN | cnt(12));
    rd(1'b1, st); chk("R3 initial remain", st, 32'hA000_0000 | cnt(12));
    runEn(4);
    rd(1'b1, st); chk("R3 remain after 4", st[15:2], 8);
    repeat (5) @(negedge clk);
    rd(1'b1, st2); chk("R3 remain stable", st2, st);
    chk("R3 no advance when disabled", {31'b0, wordAdvance}, 0);

    // R6 / R7 continuous double-buffer sweep, C = 3
    for (int k = 0; k <= 9; k++) begin
      resetChan();
      wr(1'b0, EN | DBL | cnt(3));
      runEn(k);
      rd(1'b1, st);
      chk($sformatf("R6 remain k=%0d", k), st[15:2], 32'(3 - (k % 4)));
      chk($sformatf("R6 busy/eoc k=%0d", k), {30'b0, st[31], st[30]},
          {30'b0, 1'b1, (k > 3)});
      chk($sformatf("R7 ping k=%0d", k), {31'b0, pingPong}, 32'((k / 4) % 2));
      chk($sformatf("R7 ping status k=%0d", k), {31'b0, st[28]}, 32'((k / 4) % 2));
    end
    resetChan();
    wr(1'b0, EN | cnt(3));
    runEn(9);
    chk("R7 no ping without double-buffer", {31'b0, pingPong}, 0);

    // R8 flow control
    resetChan();
    wr(1'b0, EN | FLOW | cnt(20));
    globalEn = 1'b1;
    pulses = 0;
    for (int i = 0; i < 16; i++) begin
      periphReq = (i % 3 == 0) || (i == 7);
      if (periphReq) pulses++;
      #1; chk($sformatf("R8 advance follows req i=%0d", i), {31'b0, wordAdvance}, {31'b0, periphReq});
      @(negedge clk);
    end
    periphReq = 1'b0; globalEn = 1'b0;
    rd(1'b1, st); chk("R8 remain", st[15:2], 32'(20 - pulses));

    // R9 hold
    resetChan();
    wr(1'b0, EN | HOLD | cnt(7));
    globalEn = 1'b1;
    repeat (5) @(negedge clk);
    rd(1'b1, st);
    chk("R9 remain frozen", st[15:2], 7);
    chk("R9 halted bit", {31'b0, st[29]}, 1);
    globalEn = 1'b0;

    // R10 disable mid-run
    resetChan();
    wr(1'b0, EN | cnt(30));
    globalEn = 1'b1;
    repeat (3) @(negedge clk);
    regWr = 1'b1; regAddr = 1'b0; regWdata = 32'h0;
    #1; chk("R10 no advance in stop cycle", {31'b0, wordAdvance}, 0);
    @(negedge clk);
    regWr = 1'b0;
    chk("R10 busy low", {31'b0, busy}, 0);
    advCnt = 0;
    repeat (5) begin
      #1; if (wordAdvance) advCnt++;
      @(negedge clk);
    end
    chk("R10 no later advance", 32'(advCnt), 0);
    rd(1'b1, st); chk("R10 status idle", st[31:2], 0);
    globalEn = 1'b0;

    // R11 count rewrite while running
    resetChan();
    wr(1'b0, EN | cnt(5));
    wr(1'b0, EN | cnt(9));
    rd(1'b1, st); chk("R11 old count kept", st[15:2], 5);
    runEn(6);
    rd(1'b1, st); chk("R11 new count on reload", st[15:2], 9);
    resetChan();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule